// File: doc/BRIEF.md
# Dual-Reload PWM and Event Timer

This block is a 16-bit down-counter paired with two 16-bit reload registers, called A and B. In PWM mode it decrements once per instruction-cycle tick. Each time it underflows it reloads from A and B in turn and can flip its output pin. The pin therefore carries a PWM waveform whose high and low times come from the two registers, with no processor involvement once the timer is set up.

In event-counter mode the counter decrements instead on a chosen edge of an external pin, after that pin has been synchronized. Every underflow latches a pending flag tied to the register just used for the reload. Each flag has its own enable, and together they drive one interrupt line. Software clears each flag with its own strobe. A three-bit field selects the mode and the edge; every code that is not assigned stops the counter.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, pwmOut, irq and both pending flags are 0, and both enables read as 0 at the interrupt output.
- R2: In PWM modes (modeSel 3'b100 or 3'b101) the count drops by one on each clock with cycleEn high. An underflow is the count leaving 0, so a count of N underflows on the (N+1)-th enabled cycle. Cycles with cycleEn low do not count.
- R3: The first underflow after modeSel changes to a PWM code reloads from register A. Later underflows alternate B, A, B, and so on.
- R4: With modeSel 3'b101 each underflow inverts pwmOut. With 3'b100 pwmOut holds its value.
- R5: An underflow that reloads from A sets pendA. One that reloads from B sets pendB.
- R6: A pending flag stays set until its clear strobe (clrPendA or clrPendB) is high at a clock edge. A set and a clear in the same cycle leave the flag set.
- R7: irq equals (pendA AND enA) OR (pendB AND enB).
- R8: modeSel 3'b000 counts rising edges of extPin, and 3'b001 counts falling edges. The pin is synchronized by two flops. cycleEn is ignored in these modes. Every underflow reloads from A and sets pendA only.
- R9: Any other modeSel code freezes the count and sets no flag.
- R10: A high wrCount at a clock edge loads wrData into the count, overriding any decrement or underflow in that cycle. wrReloadA and wrReloadB load register A and register B.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleEn | input | 1 | Instruction-cycle tick, the count rate in PWM modes |
| modeSel | input | 3 | Mode and edge select |
| wrReloadA | input | 1 | Write wrData into reload register A |
| wrReloadB | input | 1 | Write wrData into reload register B |
| wrCount | input | 1 | Write wrData into the counter |
| wrData | input | 16 | Write data |
| extPin | input | 1 | External event input, asynchronous |
| clrPendA | input | 1 | Clear strobe for pendA |
| clrPendB | input | 1 | Clear strobe for pendB |
| enA | input | 1 | Interrupt enable for pendA |
| enB | input | 1 | Interrupt enable for pendB |
| pwmOut | output | 1 | PWM output pin |
| irq | output | 1 | Interrupt request |

## Verification
The hold-style properties assume that only wrCount can move the count outside an active mode. They also assume that a mode code seen at an edge is the code in force for that edge. The stimulus therefore changes modeSel, the write strobes and the pins only on falling clock edges, and never counts on a pending write. The event tests hold extPin steady for four cycles per level, well beyond the synchronizer latency, so every pulse produces exactly one detected edge.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam logic [2:0] MODE_EVT_RISE = 3'b000;
  localparam logic [2:0] MODE_EVT_FALL = 3'b001;
  localparam logic [2:0] MODE_PWM_HOLD = 3'b100;
  localparam logic [2:0] MODE_PWM_TOG  = 3'b101;

  typedef struct packed {
    logic dec;
    logic reload;
    logic selB;
    logic toggle;
    logic setA;
    logic setB;
  } tmrStrobe_t;
endpackage

// File: rtl/drt_ctrl.sv
module drt_ctrl
  import drt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleEn,
  input  logic [2:0] modeSel,
  input  logic       extPin,
  input  logic       wrCount,
  input  logic       countZero,
  output tmrStrobe_t strb
);
  localparam int unsigned PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pinPipe;
  logic [2:0] prevMode;
  logic nextSelB;
  logic pinNow, pinOld, edgeHit;
  logic isPwm, isEvt, modeChanged, dec, under, useB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPipe  <= '0;
      prevMode <= 3'b111;
    end else begin
      pinPipe  <= {pinPipe[PIPE_W-2:0], extPin};
      prevMode <= modeSel;
    end
  end

  assign pinNow  = pinPipe[SYNC_STAGES-1];
  assign pinOld  = pinPipe[SYNC_STAGES];
  assign edgeHit = (modeSel == MODE_EVT_FALL) ? (pinOld & ~pinNow) : (pinNow & ~pinOld);

  assign isPwm       = (modeSel == MODE_PWM_TOG) || (modeSel == MODE_PWM_HOLD);
  assign isEvt       = (modeSel == MODE_EVT_RISE) || (modeSel == MODE_EVT_FALL);
  assign modeChanged = (modeSel != prevMode);

  assign dec   = ~wrCount & (isPwm ? cycleEn : (isEvt & edgeHit));
  assign under = dec & countZero;
  assign useB  = isPwm & ~modeChanged & nextSelB;

  always_ff @(posedge clk) begin
    if (!rstN) nextSelB <= 1'b0;
    else if (under) nextSelB <= isPwm & ~useB;
    else if (!isPwm || modeChanged) nextSelB <= 1'b0;
  end

  always_comb begin
    strb.dec    = dec;
    strb.reload = under;
    strb.selB   = useB;
    strb.toggle = under & (modeSel == MODE_PWM_TOG);
    strb.setA   = under & ~useB;
    strb.setB   = under & useB;
  end
endmodule

// File: rtl/drt_datapath.sv
module drt_datapath
  import drt_pkg::*;
#(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReloadA,
  input  logic             wrReloadB,
  input  logic             wrCount,
  input  logic [TMR_W-1:0] wrData,
  input  logic             clrPendA,
  input  logic             clrPendB,
  input  logic             enA,
  input  logic             enB,
  input  tmrStrobe_t       strb,
  output logic             countZero,
  output logic [TMR_W-1:0] countVal,
  output logic             pwmOut,
  output logic             pendA,
  output logic             pendB,
  output logic             irq
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [TMR_W-1:0] regA, regB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (wrReloadA) regA <= wrData;
      if (wrReloadB) regB <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) countVal <= '0;
    else if (wrCount) countVal <= wrData;
    else if (strb.reload) countVal <= strb.selB ? regB : regA;
    else if (strb.dec) countVal <= countVal - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwmOut <= 1'b0;
      pendA  <= 1'b0;
      pendB  <= 1'b0;
    end else begin
      if (strb.toggle) pwmOut <= ~pwmOut;
      if (strb.setA) pendA <= 1'b1;
      else if (clrPendA) pendA <= 1'b0;
      if (strb.setB) pendB <= 1'b1;
      else if (clrPendB) pendB <= 1'b0;
    end
  end

  assign countZero = (countVal == '0);
  assign irq = (pendA & enA) | (pendB & enB);
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int unsigned TMR_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleEn,
  input  logic [2:0]       modeSel,
  input  logic             wrReloadA,
  input  logic             wrReloadB,
  input  logic             wrCount,
  input  logic [TMR_W-1:0] wrData,
  input  logic             extPin,
  input  logic             clrPendA,
  input  logic             clrPendB,
  input  logic             enA,
  input  logic             enB,
  output logic             pwmOut,
  output logic             irq
);
  tmrStrobe_t strb;
  logic countZero, pendA, pendB;
  logic [TMR_W-1:0] countVal;

  drt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .modeSel(modeSel),
    .extPin(extPin), .wrCount(wrCount), .countZero(countZero), .strb(strb)
  );

  drt_datapath #(.TMR_W(TMR_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrReloadA(wrReloadA), .wrReloadB(wrReloadB),
    .wrCount(wrCount), .wrData(wrData), .clrPendA(clrPendA), .clrPendB(clrPendB),
    .enA(enA), .enB(enB), .strb(strb), .countZero(countZero), .countVal(countVal),
    .pwmOut(pwmOut), .pendA(pendA), .pendB(pendB), .irq(irq)
  );
endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
  parameter int unsigned TMR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycleEn,
  input logic [2:0]       modeSel,
  input logic             wrCount,
  input logic             clrPendA,
  input logic             clrPendB,
  input logic             enA,
  input logic             enB,
  input logic             pendA,
  input logic             pendB,
  input logic             pwmOut,
  input logic             irq,
  input logic [TMR_W-1:0] countVal
);
  logic pwmMode, evtMode;
  assign pwmMode = (modeSel == 3'b100) || (modeSel == 3'b101);
  assign evtMode = (modeSel == 3'b000) || (modeSel == 3'b001);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwmMode && !cycleEn && !wrCount |=> $stable(countVal));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwmMode && !evtMode && !wrCount |=> $stable(countVal));

  // R4
  no_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == 3'b100 |=> $stable(pwmOut));

  // R8
  evt_no_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtMode && !pendB |=> !pendB);

  // R6
  pend_a_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendA && !clrPendA |=> pendA);

  // R6
  pend_b_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendB && !clrPendB |=> pendB);

  // R7
  irq_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == ((pendA && enA) || (pendB && enB)));
endmodule

bind dual_reload_timer drt_checker #(.TMR_W(TMR_W)) chk_i (
  .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .modeSel(modeSel), .wrCount(wrCount),
  .clrPendA(clrPendA), .clrPendB(clrPendB), .enA(enA), .enB(enB),
  .pendA(pendA), .pendB(pendB), .pwmOut(pwmOut), .irq(irq), .countVal(countVal)
);

// File: tb/dual_reload_timer_tb_top.sv
module dual_reload_timer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleEn = 1'b0;
  logic [2:0] modeSel = 3'b111;
  logic wrReloadA = 1'b0, wrReloadB = 1'b0, wrCount = 1'b0;
  logic [15:0] wrData = '0;
  logic extPin = 1'b0;
  logic clrPendA = 1'b0, clrPendB = 1'b0;
  logic enA = 1'b0, enB = 1'b0;
  logic pwmOut, irq;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dual_reload_timer dut_i (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .modeSel(modeSel),
    .wrReloadA(wrReloadA), .wrReloadB(wrReloadB), .wrCount(wrCount), .wrData(wrData),
    .extPin(extPin), .clrPendA(clrPendA), .clrPendB(clrPendB), .enA(enA), .enB(enB),
    .pwmOut(pwmOut), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // irq observes pendA/pendB when enables are both high
  task automatic setEn(input logic a, input logic b);
    enA = a; enB = b; #1;
  endtask

  task automatic writeWord(input int which, input logic [15:0] v);
    wrData = v;
    wrReloadA = (which == 0); wrReloadB = (which == 1); wrCount = (which == 2);
    tick(1);
    wrReloadA = 1'b0; wrReloadB = 1'b0; wrCount = 1'b0;
  endtask

  task automatic clearBoth();
    clrPendA = 1'b1; clrPendB = 1'b1;
    tick(1);
    clrPendA = 1'b0; clrPendB = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 pwmOut after reset", pwmOut, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
    setEn(1, 1);
    chk("R1 flags clear after reset", irq, 1'b0);
  endtask

  task automatic testPwmToggle();
    modeSel = 3'b111; cycleEn = 1'b0;
    writeWord(0, 16'd3);
    writeWord(1, 16'd1);
    writeWord(2, 16'd2);
    setEn(1, 0);
    modeSel = 3'b101; cycleEn = 1'b1;
    tick(2);
    chk("R2 no underflow before N+1 cycles", irq, 1'b0);
    chk("R4 pwm low before underflow", pwmOut, 1'b0);
    tick(1);
    chk("R3 R5 first underflow sets pendA", irq, 1'b1);
    chk("R4 first toggle", pwmOut, 1'b1);
    clrPendA = 1'b1; tick(1); clrPendA = 1'b0;
    chk("R6 clear strobe drops pendA", irq, 1'b0);
    setEn(0, 1);
    tick(2);
    chk("R3 reload A length respected", irq, 1'b0);
    tick(1);
    chk("R3 R5 second underflow sets pendB", irq, 1'b1);
    chk("R4 second toggle", pwmOut, 1'b0);
    setEn(1, 0);
    chk("R7 pendB masked with enB low", irq, 1'b0);
    tick(1);
    chk("R3 reload B length respected", irq, 1'b0);
    tick(1);
    chk("R3 third underflow back to A", irq, 1'b1);
    chk("R4 third toggle", pwmOut, 1'b1);
    modeSel = 3'b111; cycleEn = 1'b0;
    clearBoth();
  endtask

  task automatic testStopAndHold();
    writeWord(2, 16'd0);
    setEn(1, 1);
    cycleEn = 1'b1;
    tick(6);
    chk("R9 stopped code sets no flag", irq, 1'b0);
    modeSel = 3'b100;
    cycleEn = 1'b0;
    tick(3);
    chk("R2 cycleEn low does not count", irq, 1'b0);
    cycleEn = 1'b1;
    tick(1);
    chk("R9 count held at zero then underflows", irq, 1'b1);
    chk("R4 no toggle in 3'b100", pwmOut, 1'b1);
    setEn(0, 1);
    chk("R5 first underflow is A not B", irq, 1'b0);
    tick(3);
    chk("R3 B not reached early", irq, 1'b0);
    tick(1);
    chk("R5 pendB after A period", irq, 1'b1);
    chk("R4 still no toggle", pwmOut, 1'b1);
    setEn(1, 1);
    cycleEn = 1'b0;
    tick(4);
    chk("R6 flags persist without clear", irq, 1'b1);
    modeSel = 3'b111;
    clearBoth();
    chk("R6 both cleared", irq, 1'b0);
  endtask

  task automatic testEventRise();
    extPin = 1'b0;
    writeWord(0, 16'd5);
    writeWord(2, 16'd1);
    setEn(1, 1);
    modeSel = 3'b000; cycleEn = 1'b1;
    tick(4);
    extPin = 1'b1; tick(4); extPin = 1'b0; tick(4);
    chk("R8 one rising edge, cycleEn ignored", irq, 1'b0);
    extPin = 1'b1; tick(4); extPin = 1'b0; tick(4);
    chk("R8 second rising edge underflows", irq, 1'b1);
    setEn(0, 1);
    chk("R8 event underflow sets no pendB", irq, 1'b0);
    modeSel = 3'b111; cycleEn = 1'b0;
    clearBoth();
  endtask

  task automatic testEventFall();
    writeWord(2, 16'd0);
    setEn(1, 0);
    modeSel = 3'b001;
    tick(4);
    extPin = 1'b1; tick(4);
    chk("R8 rising edge ignored in falling mode", irq, 1'b0);
    extPin = 1'b0; tick(4);
    chk("R8 falling edge underflows", irq, 1'b1);
    modeSel = 3'b111;
    clearBoth();
  endtask

  task automatic testWriteOverride();
    writeWord(0, 16'd2);
    setEn(1, 1);
    modeSel = 3'b100; cycleEn = 1'b1;
    wrData = 16'd4; wrCount = 1'b1;
    tick(6);
    chk("R10 repeated writes prevent underflow", irq, 1'b0);
    wrCount = 1'b0;
    tick(4);
    chk("R10 written value 4 not yet expired", irq, 1'b0);
    tick(1);
    chk("R10 underflow after written count", irq, 1'b1);
    modeSel = 3'b111; cycleEn = 1'b0;
    clearBoth();
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testPwmToggle();
    testStopAndHold();
    testEventRise();
    testEventFall();
    testWriteOverride();
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule